// File: doc/BRIEF.md
# Serial Character Echo with Hexadecimal Readout

This block listens on an asynchronous serial receive line, recovers 8-bit characters framed with one low start bit, eight data bits sent least significant bit first and one high stop bit (no parity), and keeps the most recent good character on display. The character drives eight LEDs one bit per LED, and it is decoded into two hexadecimal digits for a pair of seven-segment displays. A one-cycle strobe marks every newly accepted character.

An external echo switch decides whether each accepted character is sent back out on the transmit line with the same framing and bit rate. With the switch off the transmit pin sits at a constant low level. The bit period is a whole number of system clocks computed from the clock frequency and baud rate parameters (434 clocks for 115200 baud at 50 MHz). A 12-bit tick counter paces both directions. A start edge that has gone away by the middle of the bit is discarded, and a frame whose stop bit reads low raises a one-cycle framing-error flag and is neither shown nor echoed. A character that completes while an echo is still being sent waits in a single holding register.

Top module: `uart_echo_hex`

## Requirements
- R1: Serial frames are idle-high, with one low start bit, eight data bits least significant bit first and one high stop bit; every frame of this form is accepted as the byte it carries.
- R2: One bit lasts DIVISOR = round(CLK_HZ / BAUD) clock cycles on both lines, and the receiver samples each bit near its midpoint, timed from the falling edge of the start bit.
- R3: `led_o[i]` equals bit i of the last accepted byte, so byte 0x01 lights exactly one LED; the LEDs change only in the cycle the valid strobe is high.
- R4: `seg_hi_o` shows the upper nibble and `seg_lo_o` the lower nibble as active-high hexadecimal glyphs with segment a on bit 0 through segment g on bit 6 (0 = 0x3F, 1 = 0x06, F = 0x71; 0x01 reads "01", 0xFF reads "FF").
- R5: `byte_valid_o` is high for exactly one cycle per accepted frame and never in two consecutive cycles.
- R6: With `echo_en` high, every accepted byte is sent on `tx_out` unchanged, in arrival order, with the framing of R1 and timing of R2.
- R7: With `echo_en` low, `tx_out` is held at 0 and bytes accepted during that time are never sent.
- R8: A low pulse on the receive line that is high again at the middle of the start bit produces no strobe, no error and no display change, and the next real frame is still received.
- R9: A frame whose stop bit samples low pulses `frame_err_o` for one cycle, never together with `byte_valid_o`; the LEDs and digits keep the previous byte and nothing is echoed.
- R10: A byte accepted while an echo frame is still being sent is held and transmitted right after that frame, so two closely spaced bytes are both echoed in order.
- R11: After reset the LEDs are all off, both digits show 0 (0x3F), no strobe or error is raised, and `tx_out` is high when echo is enabled and low when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| echo_en | input | 1 | Echo switch: 1 retransmits received bytes |
| tx_out | output | 1 | Serial transmit line |
| led_o | output | 8 | Last accepted byte, one LED per bit |
| seg_hi_o | output | 7 | Upper-nibble hex digit segments (a at bit 0) |
| seg_lo_o | output | 7 | Lower-nibble hex digit segments (a at bit 0) |
| byte_valid_o | output | 1 | One-cycle strobe on each accepted byte |
| frame_err_o | output | 1 | One-cycle strobe on a stop-bit error |

## Verification
The two functions that collide are reception of a new byte and transmission of the previous echo: the bench sends two frames with the stop bit shortened to just past its sampling point, so the second byte is accepted while the first echo is still in its data or stop bits. It judges the case by decoding the transmit line independently and requiring both bytes, in order, with correct framing. A full sweep of all 256 byte values with echo on, plus framing-error, glitch and echo-off frames, checks that display, strobe and echo never disturb each other.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

   typedef enum logic [1:0] {
      LN_IDLE,
      LN_START,
      LN_DATA,
      LN_STOP
   } line_state_e;

   // Clocks per bit, rounded to the nearest whole cycle
   function automatic int unsigned clocks_per_bit(input int unsigned clk_hz,
                                                  input int unsigned baud);
      return (clk_hz + baud / 2) / baud;
   endfunction

   // Active-high hexadecimal glyph, segment a on bit 0 .. g on bit 6
   function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
      logic [6:0] g;
      case (nib)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_echo_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned DIVISOR     = 434,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 ferr_o
);

   localparam int unsigned BIT_W = $clog2(DATA_BITS);
   localparam int unsigned HALF  = DIVISOR / 2;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIVISOR - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(HALF - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_rx_core: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   prev_q;
   line_state_e            st_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [BIT_W-1:0]       bit_q;
   logic [DATA_BITS-1:0]   shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
      end
   end

   assign rx_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         st_q    <= LN_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         shreg_q <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         prev_q  <= rx_s;
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
         case (st_q)
            LN_IDLE: begin
               cnt_q <= '0;
               if (prev_q && !rx_s) begin
                  st_q <= LN_START;
               end
            end
            LN_START: begin
               if (cnt_q == CNT_MID) begin
                  cnt_q <= '0;
                  bit_q <= '0;
                  st_q  <= rx_s ? LN_IDLE : LN_DATA;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            LN_DATA: begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q   <= '0;
                  shreg_q <= {rx_s, shreg_q[DATA_BITS-1:1]};
                  if (bit_q == BIT_LAST) begin
                     st_q <= LN_STOP;
                  end else begin
                     bit_q <= bit_q + BIT_W'(1);
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q <= '0;
                  st_q  <= LN_IDLE;
                  if (rx_s) begin
                     data_o  <= shreg_q;
                     valid_o <= 1'b1;
                  end else begin
                     ferr_o <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import uart_echo_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8,
   parameter int unsigned DIVISOR   = 434,
   parameter int unsigned CNT_W     = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [DATA_BITS-1:0] data_i,
   output logic                 busy_o,
   output logic                 line_o
);

   localparam int unsigned BIT_W = $clog2(DATA_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIVISOR - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

   line_state_e          st_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [BIT_W-1:0]     bit_q;
   logic [DATA_BITS-1:0] shreg_q;

   assign busy_o = (st_q != LN_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= LN_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         shreg_q <= '0;
         line_o  <= 1'b1;
      end else begin
         case (st_q)
            LN_IDLE: begin
               line_o <= 1'b1;
               cnt_q  <= '0;
               if (load_i) begin
                  shreg_q <= data_i;
                  line_o  <= 1'b0;
                  st_q    <= LN_START;
               end
            end
            LN_START: begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q  <= '0;
                  bit_q  <= '0;
                  line_o <= shreg_q[0];
                  st_q   <= LN_DATA;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            LN_DATA: begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q <= '0;
                  if (bit_q == BIT_LAST) begin
                     line_o <= 1'b1;
                     st_q   <= LN_STOP;
                  end else begin
                     bit_q   <= bit_q + BIT_W'(1);
                     line_o  <= shreg_q[1];
                     shreg_q <= shreg_q >> 1;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               if (cnt_q == CNT_LAST) begin
                  cnt_q <= '0;
                  st_q  <= LN_IDLE;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
   import uart_echo_pkg::*;
#(
   parameter int unsigned DIGITS     = 2,
   parameter bit          ACTIVE_LOW = 1'b0
) (
   input  logic [4*DIGITS-1:0] value_i,
   output logic [7*DIGITS-1:0] seg_o
);

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [6:0] glyph;
      assign glyph = hex_glyph(value_i[4*d +: 4]);
      if (ACTIVE_LOW) begin : g_low
         assign seg_o[7*d +: 7] = ~glyph;
      end else begin : g_high
         assign seg_o[7*d +: 7] = glyph;
      end
   end

endmodule

// File: rtl/uart_echo_hex.sv
module uart_echo_hex
   import uart_echo_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned BAUD        = 115_200,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SEG_ACT_LOW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_in,
   input  logic       echo_en,
   output logic       tx_out,
   output logic [7:0] led_o,
   output logic [6:0] seg_hi_o,
   output logic [6:0] seg_lo_o,
   output logic       byte_valid_o,
   output logic       frame_err_o
);

   localparam int unsigned DATA_BITS = 8;
   localparam int unsigned DIGITS    = DATA_BITS / 4;
   localparam int unsigned DIVISOR   = clocks_per_bit(CLK_HZ, BAUD);

   if (DIVISOR < 4) begin : g_bad_div_lo
      $error("uart_echo_hex: bit period below 4 clocks");
   end
   if (DIVISOR >= (1 << CNT_W)) begin : g_bad_div_hi
      $error("uart_echo_hex: bit period does not fit the tick counter");
   end

   logic [DATA_BITS-1:0] rx_data;
   logic                 rx_vld;
   logic                 rx_ferr;
   logic [DATA_BITS-1:0] disp_q;
   logic                 vld_q;
   logic                 ferr_q;
   logic                 pend_v_q;
   logic [DATA_BITS-1:0] pend_d_q;
   logic                 tx_busy;
   logic                 tx_line;
   logic                 tx_load;
   logic                 echo_push;
   logic [7*DIGITS-1:0]  seg_all;

   uart_rx_core #(
      .DATA_BITS   (DATA_BITS),
      .DIVISOR     (DIVISOR),
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_i    (rx_in),
      .data_o  (rx_data),
      .valid_o (rx_vld),
      .ferr_o  (rx_ferr)
   );

   // Display register and event strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_q <= '0;
         vld_q  <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         vld_q  <= rx_vld;
         ferr_q <= rx_ferr;
         if (rx_vld) begin
            disp_q <= rx_data;
         end
      end
   end

   // One-entry holding register in front of the transmitter
   assign echo_push = rx_vld && echo_en;
   assign tx_load   = pend_v_q && !tx_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v_q <= 1'b0;
         pend_d_q <= '0;
      end else begin
         if (echo_push) begin
            pend_v_q <= 1'b1;
            pend_d_q <= rx_data;
         end else if (tx_load) begin
            pend_v_q <= 1'b0;
         end
      end
   end

   uart_tx_core #(
      .DATA_BITS (DATA_BITS),
      .DIVISOR   (DIVISOR),
      .CNT_W     (CNT_W)
   ) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tx_load),
      .data_i (pend_d_q),
      .busy_o (tx_busy),
      .line_o (tx_line)
   );

   hex_seg_decoder #(
      .DIGITS     (DIGITS),
      .ACTIVE_LOW (SEG_ACT_LOW)
   ) u_hex (
      .value_i (disp_q),
      .seg_o   (seg_all)
   );

   assign tx_out       = echo_en ? tx_line : 1'b0;
   assign led_o        = disp_q;
   assign seg_lo_o     = seg_all[6:0];
   assign seg_hi_o     = seg_all[13:7];
   assign byte_valid_o = vld_q;
   assign frame_err_o  = ferr_q;

endmodule

// File: rtl/uart_echo_hex_chk.sv
module uart_echo_hex_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       echo_en,
   input logic       tx_out,
   input logic [7:0] led_o,
   input logic       byte_valid_o,
   input logic       frame_err_o
);

   AST_TX_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !echo_en |-> !tx_out); // R7

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |=> !byte_valid_o); // R5

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o); // R9

   AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({byte_valid_o, frame_err_o})); // R9

   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid_o |-> $stable(led_o)); // R3

   AST_ERR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> $stable(led_o)); // R9

endmodule

bind uart_echo_hex uart_echo_hex_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .echo_en      (echo_en),
   .tx_out       (tx_out),
   .led_o        (led_o),
   .byte_valid_o (byte_valid_o),
   .frame_err_o  (frame_err_o)
);

// File: tb/uart_echo_hex_tb.sv
module uart_echo_hex_tb;

   localparam int BITLEN = 16;   // 1_600_000 / 100_000

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       echo_en = 1'b0;
   logic       tx_out;
   logic [7:0] led_o;
   logic [6:0] seg_hi_o;
   logic [6:0] seg_lo_o;
   logic       byte_valid_o;
   logic       frame_err_o;

   int nchk = 0;
   int nfail = 0;
   int vcnt = 0;
   int ecnt = 0;
   int tx_bad = 0;
   int cap_n = 0;
   int cap_bad = 0;
   logic [7:0] cap [0:511];
   bit   done = 1'b0;

   always #10 clk = ~clk;

   uart_echo_hex #(.CLK_HZ(1_600_000), .BAUD(100_000)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_in        (rx_in),
      .echo_en      (echo_en),
      .tx_out       (tx_out),
      .led_o        (led_o),
      .seg_hi_o     (seg_hi_o),
      .seg_lo_o     (seg_lo_o),
      .byte_valid_o (byte_valid_o),
      .frame_err_o  (frame_err_o)
   );

   function automatic logic [6:0] exp_glyph(input logic [3:0] n);
      case (n)
         4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;
         4'h3: return 7'h4F;  4'h4: return 7'h66;  4'h5: return 7'h6D;
         4'h6: return 7'h7D;  4'h7: return 7'h07;  4'h8: return 7'h7F;
         4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
         4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;
         default: return 7'h71;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic send_frame(input logic [7:0] b, input bit stop_v, input int stop_len);
      rx_in = 1'b0;
      step(BITLEN);
      for (int i = 0; i < 8; i++) begin
         rx_in = b[i];
         step(BITLEN);
      end
      rx_in = stop_v;
      step(stop_len);
      rx_in = 1'b1;
   endtask

   task automatic check_display(input logic [7:0] b, input string req);
      check(led_o == b, req, led_o, b);
      check({seg_hi_o, seg_lo_o} == {exp_glyph(b[7:4]), exp_glyph(b[3:0])},
            "R4 hex digits", {seg_hi_o, seg_lo_o},
            {exp_glyph(b[7:4]), exp_glyph(b[3:0])});
   endtask

   // Event counters and echo-off line monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid_o) vcnt++;
         if (frame_err_o)  ecnt++;
         if (!echo_en && tx_out) tx_bad++;
      end
   end

   // Independent decoder of the transmit line
   initial begin
      logic prev_tx = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && echo_en && prev_tx && !tx_out) begin
            logic [7:0] b;
            repeat (BITLEN / 2) @(negedge clk);
            if (tx_out) cap_bad++;
            for (int i = 0; i < 8; i++) begin
               repeat (BITLEN) @(negedge clk);
               b[i] = tx_out;
            end
            repeat (BITLEN) @(negedge clk);
            if (!tx_out) cap_bad++;
            cap[cap_n] = b;
            cap_n++;
            prev_tx = 1'b1;
         end else begin
            prev_tx = tx_out;
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int v0, e0, c0;
      logic [7:0] last;

      // R11: reset state, echo off then on
      step(5);
      rst_n = 1'b1;
      step(3);
      check(led_o == 8'h00, "R11 leds after reset", led_o, 0);
      check(seg_hi_o == 7'h3F && seg_lo_o == 7'h3F, "R11 digits after reset",
            {seg_hi_o, seg_lo_o}, 14'h1FBF);
      check(!byte_valid_o && !frame_err_o, "R11 no strobes",
            {byte_valid_o, frame_err_o}, 0);
      check(tx_out == 1'b0, "R11 tx low with echo off", tx_out, 0);
      echo_en = 1'b1;
      step(2);
      check(tx_out == 1'b1, "R11 tx idle high with echo on", tx_out, 1);

      // R1 R2 R3 R4 R5 R6: sweep of every byte value with echo on
      for (int b = 0; b < 256; b++) begin
         v0 = vcnt;
         send_frame(8'(b), 1'b1, BITLEN);
         step(BITLEN);
         check(vcnt == v0 + 1, "R5 one strobe per frame", vcnt - v0, 1);
         check_display(8'(b), "R1 R2 R3 received byte on leds");
      end
      step(12 * BITLEN);
      check(cap_n == 256, "R6 echo count", cap_n, 256);
      for (int b = 0; b < 256; b++) begin
         check(cap[b] == 8'(b), "R6 echoed byte", cap[b], b);
      end
      check(cap_bad == 0, "R6 echo framing", cap_bad, 0);

      // R3 R4: named corner bytes
      send_frame(8'h01, 1'b1, BITLEN);
      step(BITLEN);
      check($countones(led_o) == 1, "R3 code 1 lights one led", $countones(led_o), 1);
      check(seg_hi_o == 7'h3F && seg_lo_o == 7'h06, "R4 shows 01",
            {seg_hi_o, seg_lo_o}, {7'h3F, 7'h06});
      send_frame(8'hFF, 1'b1, BITLEN);
      step(BITLEN);
      check(seg_hi_o == 7'h71 && seg_lo_o == 7'h71, "R4 shows FF",
            {seg_hi_o, seg_lo_o}, {7'h71, 7'h71});
      step(12 * BITLEN);

      // R10: second byte arrives while the first echo is still going out
      c0 = cap_n;
      send_frame(8'hA5, 1'b1, 12);
      send_frame(8'h3C, 1'b1, 12);
      step(24 * BITLEN);
      check(cap_n == c0 + 2, "R10 both close bytes echoed", cap_n - c0, 2);
      check(cap[c0] == 8'hA5, "R10 first held order", cap[c0], 8'hA5);
      check(cap[c0 + 1] == 8'h3C, "R10 second held order", cap[c0 + 1], 8'h3C);
      check_display(8'h3C, "R10 display shows last");

      // R9: stop bit low
      last = 8'h3C;
      v0 = vcnt; e0 = ecnt; c0 = cap_n;
      send_frame(8'h5A, 1'b0, BITLEN);
      step(BITLEN);
      step(12 * BITLEN);
      check(ecnt == e0 + 1, "R9 framing error strobe", ecnt - e0, 1);
      check(vcnt == v0, "R9 no valid strobe", vcnt - v0, 0);
      check(cap_n == c0, "R9 nothing echoed", cap_n - c0, 0);
      check_display(last, "R9 display kept");

      // R8: short start glitch, then a real frame
      v0 = vcnt; e0 = ecnt;
      rx_in = 1'b0;
      step(4);
      rx_in = 1'b1;
      step(4 * BITLEN);
      check(vcnt == v0 && ecnt == e0, "R8 glitch ignored",
            (vcnt - v0) + (ecnt - e0), 0);
      check_display(last, "R8 display kept after glitch");
      send_frame(8'hC3, 1'b1, BITLEN);
      step(BITLEN);
      check(vcnt == v0 + 1, "R8 frame after glitch", vcnt - v0, 1);
      check_display(8'hC3, "R8 byte after glitch");
      step(12 * BITLEN);

      // R7: echo off, display still updates, line stays low
      echo_en = 1'b0;
      c0 = cap_n;
      send_frame(8'h96, 1'b1, BITLEN);
      step(BITLEN);
      check_display(8'h96, "R7 display with echo off");
      step(12 * BITLEN);
      check(tx_bad == 0, "R7 tx held low", tx_bad, 0);
      echo_en = 1'b1;
      step(12 * BITLEN);
      check(cap_n == c0, "R7 disabled byte never sent", cap_n - c0, 0);

      finish_run();
   end

endmodule